// File: doc/BRIEF.md
# Text Glyph Pixel Serializer

This block sits between a character-mode video memory and the pixel output stage of a display pipeline. Video memory holds character codes rather than pixels: each 16-bit word carries two 8-bit codes. The block requests one memory word for every group of two character cells (16 pixels). It turns each code, combined with the current glyph row, into an 8-pixel row pattern from an internal 8×8 font lookup. It then serializes that pattern one bit per pixel clock onto three 8-bit colour channels, which are all-ones for a lit pixel and all-zeros otherwise.

A separate timing generator supplies the pixel position inside the current two-character group, the glyph row, and a blanking flag. An external arbiter answers each request with a word and a one-cycle valid strobe. The returned word goes into a holding register. At the end of each group it is transferred into a working register that supplies both codes of the next group, upper byte first. A word can therefore arrive at any point in a group without disturbing the characters on screen.

Top module: `txt_glyph_serializer`

## Requirements
- R1: While reset is low, and at the first output after it is released, all colour channels and `mem_req` are 0. Reset clears the holding word, the working word and the pixel shifter to zero, so the first group after reset shows 8 black pixels and then the glyph of code 0x00.
- R2: `mem_req` is high for exactly one cycle, in the cycle after the cycle in which `col` equals `REQ_SLOT` (default 0), and low otherwise. With `col` stepping 0..15 this is once per 16 pixels.
- R3: `mem_data` is taken into the holding register only in a cycle where `mem_valid` is high. Data presented with `mem_valid` low has no effect on later pixels.
- R4: The word held at the end of a group (`col` = 15) is shown in the next group. Its bits [15:8] form the code for pixels 0..7 and its bits [7:0] form the code for pixels 8..15.
- R5: The font row for code `c` and glyph row `r` is the byte {c[6:0], 1} rotated left by `r` bit positions. Bit 7 of the code does not affect the lookup.
- R6: Within a cell, font bit 7 is the leftmost pixel and each following pixel takes the next lower bit. The glyph row is sampled on the last pixel of the preceding cell (`col` = 7 for the second cell, `col` = 15 for the first cell of the next group).
- R7: A lit pixel drives 0xFF on all three channels and an unlit pixel drives 0x00. The colour for the pixel presented on the inputs in one cycle appears on the outputs after that cycle's clock edge.
- R8: `blank` high forces 0x00 on all channels for that pixel. Serialization keeps advancing, so pixels after the blanked ones keep their normal positions.
- R9: A word arriving during a group (including on the cycle of the mid-group load at `col` = 7) does not change the second character of the group currently shown.
- R10: A word arriving with `mem_valid` high in the same cycle as `col` = 15 is used directly for the next group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| col | input | 4 | Pixel position inside the current two-character group (0..15) |
| row | input | 3 | Glyph row of the current text line (0..7) |
| blank | input | 1 | High during horizontal or vertical blanking |
| mem_data | input | 16 | Word returned from video memory: two character codes |
| mem_valid | input | 1 | One-cycle strobe qualifying `mem_data` |
| mem_req | output | 1 | One-cycle request for the next memory word |
| red | output | 8 | Red channel, 0xFF or 0x00 |
| green | output | 8 | Green channel, 0xFF or 0x00 |
| blue | output | 8 | Blue channel, 0xFF or 0x00 |

## Verification
The returning memory word can coincide with a glyph load. When it coincides with the end-of-group load, the new word must feed the next group at once. When it coincides with the mid-group load, the word on screen must keep supplying its second code. Table vectors place the data-valid strobe exactly on position 15, exactly on position 7, and at other points in the group. Each case is judged by comparing the full 16-pixel pattern of the following group against glyphs the bench computes from the font rule, with rows and blanking applied.

// File: rtl/txtser_pkg.sv
// Shared definitions for the text glyph serializer.
// Holds the colour channel ordering used to pack and unpack the RGB bus.
package txtser_pkg;
    typedef enum logic [1:0] {
        CH_RED   = 2'd0,
        CH_GREEN = 2'd1,
        CH_BLUE  = 2'd2
    } chan_e;

    localparam int NUM_CHAN = 3;
endpackage

// File: rtl/txtser_font_rom.sv
// Combinational font lookup.
// Maps a 7-bit character index and a glyph row onto one glyph row of
// GLYPH_W pixels; bit GLYPH_W-1 is the leftmost pixel. The pattern is
// computed: the seed {index, 1} rotated left by the row number.
// Assumes: the number of glyph rows does not exceed GLYPH_W.
module txtser_font_rom #(
    parameter  int GLYPH_W = 8,
    parameter  int ROW_W   = 3,
    localparam int IDX_W   = GLYPH_W - 1
) (
    input  logic [IDX_W-1:0]   idx,
    input  logic [ROW_W-1:0]   row,
    output logic [GLYPH_W-1:0] bits
);
    logic [GLYPH_W-1:0]   seed;
    logic [2*GLYPH_W-1:0] dbl;

    // Rotate the seed by the row number through a doubled copy.
    always_comb begin
        seed = {idx, 1'b1};
        dbl  = {seed, seed} << row;
        bits = dbl[2*GLYPH_W-1 -: GLYPH_W];
    end
endmodule

// File: rtl/txtser_code_fetch.sv
// Memory request and character code selection.
// Issues one request per character group, holds the returned word and
// hands out the character codes of each group, upper code first.
// Assumes: col steps through 0..GROUP-1 once per pixel, and GROUP is a
// power of two. The word for a group must arrive by its last pixel.
module txtser_code_fetch #(
    parameter  int GLYPH_W  = 8,
    parameter  int CHARS    = 2,
    parameter  int REQ_SLOT = 0,
    localparam int CELL_W   = $clog2(GLYPH_W),
    localparam int COL_W    = $clog2(GLYPH_W * CHARS),
    localparam int WORD_W   = GLYPH_W * CHARS,
    localparam int IDX_W    = GLYPH_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COL_W-1:0]  col,
    input  logic [WORD_W-1:0] mem_data,
    input  logic              mem_valid,
    output logic              mem_req,
    output logic [IDX_W-1:0]  code,
    output logic              load
);
    logic [WORD_W-1:0] pend_q;
    logic [WORD_W-1:0] act_q;
    logic [WORD_W-1:0] word_now;
    logic              cell_end;
    logic              grp_end;

    // Decode cell and group boundaries and pick the code to look up.
    always_comb begin
        cell_end = &col[CELL_W-1:0];
        grp_end  = &col;
        load     = cell_end;
        word_now = mem_valid ? mem_data : pend_q;
        code     = grp_end ? word_now[WORD_W-2 -: IDX_W]
                           : act_q[WORD_W-2 -: IDX_W];
    end

    // Hold the most recently returned memory word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else if (mem_valid)
            pend_q <= mem_data;
    end

    // Working word: refilled at group end, moved up one code per cell.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_q <= '0;
        else if (grp_end)
            act_q <= word_now << GLYPH_W;
        else if (cell_end)
            act_q <= act_q << GLYPH_W;
    end

    // One request pulse per group at the configured position.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mem_req <= 1'b0;
        else
            mem_req <= (col == COL_W'(REQ_SLOT));
    end

    // R2: a request never lasts longer than one cycle.
    assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
endmodule

// File: rtl/txtser_pix_shift.sv
// Pixel shifter and colour driver.
// Loads a glyph row on the last pixel of a cell, shifts one bit per
// pixel with the leftmost pixel in the top bit, and drives every colour
// channel all-ones or all-zeros, black while blanking.
// Assumes: load is high exactly on the last pixel of each cell.
module txtser_pix_shift
    import txtser_pkg::*;
#(
    parameter  int GLYPH_W = 8,
    parameter  int COLOR_W = 8,
    localparam int RGB_W   = NUM_CHAN * COLOR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [GLYPH_W-1:0] glyph,
    input  logic               blank,
    output logic [RGB_W-1:0]   rgb
);
    logic [GLYPH_W-1:0] sh_q;
    logic [RGB_W-1:0]   rgb_q;

    // Load a fresh glyph row or move to the next pixel.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sh_q <= '0;
        else if (load)
            sh_q <= glyph;
        else
            sh_q <= {sh_q[GLYPH_W-2:0], 1'b0};
    end

    // One output register per colour channel.
    for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
        // Expand the current pixel bit to a full channel value.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rgb_q[ch*COLOR_W +: COLOR_W] <= '0;
            else
                rgb_q[ch*COLOR_W +: COLOR_W] <= (blank || !sh_q[GLYPH_W-1]) ? '0 : '1;
        end
    end

    assign rgb = rgb_q;

    // R8: a blanked pixel comes out black on every channel.
    assert_blank_black_R8: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> (rgb_q == '0));

    // R7: all channels agree and each is fully on or fully off.
    assert_mono_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rgb_q == {NUM_CHAN{rgb_q[COLOR_W-1:0]}}) &&
        ((rgb_q[COLOR_W-1:0] == '0) || (rgb_q[COLOR_W-1:0] == '1)));

    // R6: between loads the shifter only drops lit bits, never gains one.
    assert_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($countones(sh_q) <= $past($countones(sh_q))));
endmodule

// File: rtl/txt_glyph_serializer.sv
// Text glyph pixel serializer, top level.
// Requests one video memory word per two-character group, expands each
// character code through the font lookup and serializes the glyph rows
// onto three colour channels.
// Assumes: col and row come from a timing generator that steps col once
// per pixel clock. Colour output lags the pixel inputs by one clock.
module txt_glyph_serializer
    import txtser_pkg::*;
#(
    parameter  int GLYPH_W        = 8,
    parameter  int GLYPH_H        = 8,
    parameter  int CHARS_PER_WORD = 2,
    parameter  int COLOR_W        = 8,
    parameter  int REQ_SLOT       = 0,
    localparam int COL_W          = $clog2(GLYPH_W * CHARS_PER_WORD),
    localparam int ROW_W          = $clog2(GLYPH_H),
    localparam int WORD_W         = GLYPH_W * CHARS_PER_WORD,
    localparam int IDX_W          = GLYPH_W - 1,
    localparam int RGB_W          = NUM_CHAN * COLOR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [COL_W-1:0]   col,
    input  logic [ROW_W-1:0]   row,
    input  logic               blank,
    input  logic [WORD_W-1:0]  mem_data,
    input  logic               mem_valid,
    output logic               mem_req,
    output logic [COLOR_W-1:0] red,
    output logic [COLOR_W-1:0] green,
    output logic [COLOR_W-1:0] blue
);
    logic [IDX_W-1:0]   code;
    logic               load;
    logic [GLYPH_W-1:0] glyph;
    logic [RGB_W-1:0]   rgb;

    txtser_code_fetch #(
        .GLYPH_W  (GLYPH_W),
        .CHARS    (CHARS_PER_WORD),
        .REQ_SLOT (REQ_SLOT)
    ) i_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .col       (col),
        .mem_data  (mem_data),
        .mem_valid (mem_valid),
        .mem_req   (mem_req),
        .code      (code),
        .load      (load)
    );

    txtser_font_rom #(
        .GLYPH_W (GLYPH_W),
        .ROW_W   (ROW_W)
    ) i_font (
        .idx  (code),
        .row  (row),
        .bits (glyph)
    );

    txtser_pix_shift #(
        .GLYPH_W (GLYPH_W),
        .COLOR_W (COLOR_W)
    ) i_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .glyph (glyph),
        .blank (blank),
        .rgb   (rgb)
    );

    assign red   = rgb[int'(CH_RED)   * COLOR_W +: COLOR_W];
    assign green = rgb[int'(CH_GREEN) * COLOR_W +: COLOR_W];
    assign blue  = rgb[int'(CH_BLUE)  * COLOR_W +: COLOR_W];
endmodule

// File: tb/test_txt_glyph_serializer.sv
// Self-checking bench for the text glyph pixel serializer.
// Inputs change at the falling edge; outputs are read at the falling edge
// after the rising edge that consumed the pixel's inputs.
module test_txt_glyph_serializer;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int NVEC       = 10;

    // Vector: {word[15:0], row[3:0], valid_slot[3:0], blank_mask[15:0]}
    // blank_mask bit 15-c blanks pixel c of the group.
    localparam logic [39:0] VEC [NVEC] = '{
        40'h4865_0_3_0000,  // primes the pipeline, shows post-reset state (R1)
        40'h6C6C_0_9_0000,  // shows 4865
        40'h6F20_3_F_0000,  // shows 6C6C; data on position 15 (R10)
        40'hC141_3_7_0000,  // shows 6F20; data on mid-group load (R9)
        40'hFF00_5_0_0000,  // shows C141 (bit 7 ignored, R5); early data (R9)
        40'h5A7A_7_F_FFFF,  // shows FF00 fully blanked (R8)
        40'h2121_7_2_0F0F,  // shows 5A7A partly blanked (R8)
        40'h1234_1_F_8001,  // shows 2121
        40'h7E31_2_A_0000,  // shows 1234
        40'h0A0D_4_D_0000   // shows 7E31
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  col;
    logic [2:0]  row;
    logic        blank;
    logic [15:0] mem_data;
    logic        mem_valid;
    logic        mem_req;
    logic [7:0]  red, green, blue;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    txt_glyph_serializer i_txt_glyph_serializer (
        .clk       (clk),
        .rst_n     (rst_n),
        .col       (col),
        .row       (row),
        .blank     (blank),
        .mem_data  (mem_data),
        .mem_valid (mem_valid),
        .mem_req   (mem_req),
        .red       (red),
        .green     (green),
        .blue      (blue)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Font rule from R5: seed {code[6:0],1}, rotated left by row, one step at a time.
    function automatic logic [7:0] ref_glyph(input logic [7:0] c, input logic [2:0] r);
        logic [7:0] b;
        b = {c[6:0], 1'b1};
        for (int k = 0; k < 8; k++)
            if (k < int'(r)) b = {b[6:0], b[7]};
        return b;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one pixel and read back its colour and the request line.
    task automatic run_pixel(input logic [3:0] c, input logic [2:0] r, input logic bl,
                             input logic vld, input logic [15:0] d,
                             output logic on, output logic chan_bad, output logic req);
        col = c; row = r; blank = bl; mem_valid = vld; mem_data = d;
        @(posedge clk);
        @(negedge clk);
        on       = (red == 8'hFF);
        chan_bad = !((red == green) && (green == blue) && (red == 8'h00 || red == 8'hFF));
        req      = mem_req;
    endtask

    // Run a full 16-pixel group; data is junk unless valid at the slot.
    task automatic run_group(input logic [15:0] word, input logic [2:0] r,
                             input logic [15:0] mask, input logic [3:0] slot,
                             input bit vld_en, output logic [15:0] pix,
                             output logic bad, output logic req_ok);
        logic on, cb, rq, v;
        bad = 1'b0; req_ok = 1'b1; pix = '0;
        for (int c = 0; c < 16; c++) begin
            v = vld_en && (4'(c) == slot);
            run_pixel(4'(c), r, mask[15-c], v, v ? word : 16'hBEEF, on, cb, rq);
            pix[15-c] = on;
            bad       = bad | cb;
            if (rq != (c == 0)) req_ok = 1'b0;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] model_pend, exp, pix;
        logic [2:0]  prev_row;
        logic        bad, req_ok, on, cb, rq;
        string       tag;

        rst_n = 1'b0; col = '0; row = '0; blank = 1'b0;
        mem_data = '0; mem_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs quiet during reset
        check(red == 0 && green == 0 && blue == 0 && mem_req == 0, "R1 in reset",
              {7'b0, mem_req, red}, 16'h0000);
        rst_n = 1'b1;

        // Table walk: each group shows the word held at the end of the previous one.
        model_pend = '0;
        prev_row   = '0;
        for (int v = 0; v < NVEC; v++) begin
            logic [15:0] w, m;
            logic [2:0]  r;
            logic [3:0]  s;
            w = VEC[v][39:24]; r = VEC[v][22:20]; s = VEC[v][19:16]; m = VEC[v][15:0];
            if (v == 0) begin
                exp = {8'h00, ref_glyph(8'h00, r)} & ~m;
                tag = "R1 first group";
            end else begin
                exp = {ref_glyph(model_pend[15:8], prev_row), ref_glyph(model_pend[7:0], r)} & ~m;
                tag = "R4 R5 R6";
                if (m != 0) tag = {tag, " R8"};
                if (VEC[v-1][19:16] == 4'hF) tag = {tag, " R10"};
                if (VEC[v-1][19:16] <= 4'h7 || s <= 4'h7) tag = {tag, " R9"};
            end
            run_group(w, r, m, s, 1'b1, pix, bad, req_ok);
            check(pix == exp, tag, pix, exp);
            check(!bad, "R7 channel levels", {15'b0, bad}, 16'h0000);
            check(req_ok, "R2 request timing", {15'b0, req_ok}, 16'h0001);
            model_pend = w;
            prev_row   = r;
        end

        // R3: two groups with junk data and valid low keep showing the held word.
        exp = {ref_glyph(model_pend[15:8], prev_row), ref_glyph(model_pend[7:0], 3'd2)};
        run_group(16'h0, 3'd2, 16'h0, 4'h0, 1'b0, pix, bad, req_ok);
        check(pix == exp, "R3 no valid, group A", pix, exp);
        exp = {ref_glyph(model_pend[15:8], 3'd2), ref_glyph(model_pend[7:0], 3'd2)};
        run_group(16'h0, 3'd2, 16'h0, 4'h0, 1'b0, pix, bad, req_ok);
        check(pix == exp, "R3 no valid, group B", pix, exp);

        // R1: reset in mid-group, with a load position and valid data presented.
        for (int c = 0; c < 5; c++) run_pixel(4'(c), 3'd1, 1'b0, 1'b0, 16'h0, on, cb, rq);
        rst_n = 1'b0; col = 4'd7; row = 3'd6; blank = 1'b0;
        mem_valid = 1'b1; mem_data = 16'hFFFF;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(red == 0 && green == 0 && blue == 0 && mem_req == 0, "R1 mid-stream reset",
              {7'b0, mem_req, red}, 16'h0000);
        rst_n = 1'b1;
        exp = {8'h00, ref_glyph(8'h00, 3'd6)};
        run_group(16'h0, 3'd6, 16'h0, 4'h0, 1'b0, pix, bad, req_ok);
        check(pix == exp, "R1 cleared state after reset", pix, exp);
        check(req_ok, "R2 request after reset", {15'b0, req_ok}, 16'h0001);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule